// File: doc/BRIEF.md
# Event Code Mapping Decoder

This block sits on the receive side of a timing-event link. Each event-clock cycle it may receive one 8-bit event code. It looks the code up in a host-loaded mapping memory with one entry per code. Each entry is a 128-bit word that describes what the code should cause. One cycle later the block emits one-cycle strobes: a vector of trigger strobes, a vector of set strobes and a vector of clear strobes for the pulse generators, plus a vector of eleven internal-function strobes. The pulse generators, the event FIFO and the timestamp logic that consume these strobes sit outside this block.

The code input is a stream with a valid qualifier only. The block is always ready, so there is no back-pressure. A code presented with `evt_valid` high is always consumed at that clock edge, and codes may arrive on every cycle. The output side has no ready signal either. `out_valid` marks the single cycle in which the strobes for one code are present. The host loads the memory through a plain write port, one full 128-bit word per cycle. A small set of well-known codes raise their function strobe even when their mapping bit is clear.

Top module: `evm_decoder`

## Requirements
- R1: After reset, and until the first code is accepted, `out_valid`, `pg_trig`, `pg_set`, `pg_clr` and `fn_strobe` are all zero.
- R2: A code accepted with `evt_valid` high at clock edge k drives `out_valid` and its strobes in the cycle after edge k only. If no code is accepted at edge k, every output is zero after that edge.
- R3: For a nonzero code, `pg_clr[n]` equals word bit n, `pg_set[n]` equals word bit 32+n, and `pg_trig[n]` equals word bit 64+n of that code's mapping word.
- R4: The `fn_strobe` positions and the word bits they follow are: [0] seconds shift '0' (bit 96), [1] seconds shift '1' (bit 97), [2] timestamp clock (bit 98), [3] timestamp reset (bit 99), [4] prescaler reset (bit 100), [5] heartbeat (bit 101), [6] stop FIFO (bit 123), [7] forward upstream (bit 124), [8] LED event (bit 125), [9] timestamp latch (bit 126), [10] save to FIFO (bit 127).
- R5: Word bits 102 to 122 have no effect on any output. A code whose word has only those bits set gives `out_valid` high with all strobes zero.
- R6: Event code 0 gives neither `out_valid` nor any strobe, whatever its mapping word holds.
- R7: Some codes raise their function strobe even when the word bit is clear: 0x70 raises fn_strobe[0], 0x71 raises [1], 0x7C raises [2], 0x7D raises [3], 0x7B raises [4], 0x7A raises [5], and 0x79 raises [6]. This holds when `USE_DEFAULTS` is 1.
- R8: A write with `wr_en` high at edge k stores `wr_data` at `wr_addr`. A lookup of that code accepted at any later edge uses the new word.
- R9: When a lookup and a write to the same code happen at the same edge, the lookup returns the word held before the write.
- R10: Codes accepted on consecutive edges produce outputs on consecutive cycles, in order, with none dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | An event code is present this cycle |
| evt_code | input | 8 | Received event code |
| wr_en | input | 1 | Host write strobe for the mapping memory |
| wr_addr | input | 8 | Event code whose word is written |
| wr_data | input | 128 | Mapping word to store |
| out_valid | output | 1 | Strobes for one nonzero code are present |
| pg_trig | output | NUM_GEN | Pulse-generator trigger strobes |
| pg_set | output | NUM_GEN | Pulse-generator set strobes |
| pg_clr | output | NUM_GEN | Pulse-generator clear strobes |
| fn_strobe | output | 11 | Internal-function strobes, positions per R4 |

## Verification
All 255 codes are loaded with pseudo-random words and then streamed back to back. This separates the three pulse fields and the function bit positions from one another, and it catches any loss of order or throughput in a continuous stream. Separate runs use sparse codes with idle gaps and code 0 mixed in. These show that strobes last exactly one cycle and that code 0 stays silent. The well-known codes are sent with all-zero words and again with their own bit set, which separates the default path from the mapped path. A word holding only reserved bits shows that those bits are dropped. A write and a read of the same code at the same edge, followed by a second read, shows the old-then-new ordering.

// File: rtl/evm_pkg.sv
`timescale 1ns/1ps
package evm_pkg;
  localparam int CODE_W  = 8;
  localparam int WORD_W  = 128;
  localparam int FIELD_W = 32;
  localparam int FN_N    = 11;

  // word bit that feeds function strobe j
  function automatic int fn_bit(input int j);
    return (j < 6) ? (96 + j) : (117 + j);
  endfunction

  // whether function j has a fixed default code
  function automatic bit fn_has_def(input int j);
    return (j <= 6);
  endfunction

  function automatic logic [CODE_W-1:0] fn_def_code(input int j);
    logic [CODE_W-1:0] c;
    case (j)
      0: c = 8'h70;
      1: c = 8'h71;
      2: c = 8'h7C;
      3: c = 8'h7D;
      4: c = 8'h7B;
      5: c = 8'h7A;
      6: c = 8'h79;
      default: c = 8'h00;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/evm_word_pack.sv
`timescale 1ns/1ps
module evm_word_pack
  import evm_pkg::*;
#(
  parameter int NUM_GEN = 32,
  localparam int PW = FN_N + 3*NUM_GEN
) (
  input  logic [WORD_W-1:0] word_in,
  output logic [PW-1:0]     packed_out
);
  for (genvar n = 0; n < NUM_GEN; n++) begin : g_pg
    assign packed_out[n]             = word_in[n];
    assign packed_out[NUM_GEN + n]   = word_in[FIELD_W + n];
    assign packed_out[2*NUM_GEN + n] = word_in[2*FIELD_W + n];
  end
  for (genvar j = 0; j < FN_N; j++) begin : g_fn
    assign packed_out[3*NUM_GEN + j] = word_in[fn_bit(j)];
  end
endmodule

// File: rtl/evm_map_ram.sv
`timescale 1ns/1ps
module evm_map_ram #(
  parameter int AW = 8,
  parameter int DW = 107,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/evm_pulse_gate.sv
`timescale 1ns/1ps
module evm_pulse_gate #(
  parameter int NUM_GEN = 32
) (
  input  logic               hit,
  input  logic [NUM_GEN-1:0] field,
  output logic [NUM_GEN-1:0] strobe
);
  for (genvar n = 0; n < NUM_GEN; n++) begin : g_bit
    assign strobe[n] = hit & field[n];
  end
endmodule

// File: rtl/evm_fn_decode.sv
`timescale 1ns/1ps
module evm_fn_decode
  import evm_pkg::*;
#(
  parameter bit USE_DEFAULTS = 1'b1
) (
  input  logic              hit,
  input  logic [CODE_W-1:0] code,
  input  logic [FN_N-1:0]   mapped,
  output logic [FN_N-1:0]   strobe
);
  for (genvar j = 0; j < FN_N; j++) begin : g_fn
    if (USE_DEFAULTS && fn_has_def(j)) begin : g_def
      assign strobe[j] = hit & (mapped[j] | (code == fn_def_code(j)));
    end else begin : g_map
      assign strobe[j] = hit & mapped[j];
    end
  end
endmodule

// File: rtl/evm_decoder.sv
`timescale 1ns/1ps
module evm_decoder
  import evm_pkg::*;
#(
  parameter int NUM_GEN      = 32,
  parameter bit USE_DEFAULTS = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_valid,
  input  logic [CODE_W-1:0]     evt_code,
  input  logic                  wr_en,
  input  logic [CODE_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  output logic                  out_valid,
  output logic [NUM_GEN-1:0]    pg_trig,
  output logic [NUM_GEN-1:0]    pg_set,
  output logic [NUM_GEN-1:0]    pg_clr,
  output logic [FN_N-1:0]       fn_strobe
);
  localparam int PW = FN_N + 3*NUM_GEN;

  logic [PW-1:0]     wr_packed;
  logic [PW-1:0]     rd_packed;
  logic              vld_q;
  logic [CODE_W-1:0] code_q;
  logic              hit;

  evm_word_pack #(.NUM_GEN(NUM_GEN)) u_pack (
    .word_in    (wr_data),
    .packed_out (wr_packed)
  );

  evm_map_ram #(.AW(CODE_W), .DW(PW)) u_ram (
    .clk     (clk),
    .rd_en   (evt_valid),
    .rd_addr (evt_code),
    .rd_data (rd_packed),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_packed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q  <= evt_valid;
      code_q <= evt_code;
    end
  end

  assign hit       = vld_q & (code_q != '0);
  assign out_valid = hit;

  evm_pulse_gate #(.NUM_GEN(NUM_GEN)) u_clr (
    .hit (hit), .field (rd_packed[NUM_GEN-1:0]), .strobe (pg_clr)
  );
  evm_pulse_gate #(.NUM_GEN(NUM_GEN)) u_set (
    .hit (hit), .field (rd_packed[2*NUM_GEN-1:NUM_GEN]), .strobe (pg_set)
  );
  evm_pulse_gate #(.NUM_GEN(NUM_GEN)) u_trig (
    .hit (hit), .field (rd_packed[3*NUM_GEN-1:2*NUM_GEN]), .strobe (pg_trig)
  );

  evm_fn_decode #(.USE_DEFAULTS(USE_DEFAULTS)) u_fn (
    .hit    (hit),
    .code   (code_q),
    .mapped (rd_packed[PW-1:3*NUM_GEN]),
    .strobe (fn_strobe)
  );
endmodule

// File: rtl/evm_decoder_chk.sv
`timescale 1ns/1ps
module evm_decoder_chk
  import evm_pkg::*;
#(
  parameter int NUM_GEN      = 32,
  parameter bit USE_DEFAULTS = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [CODE_W-1:0]  evt_code,
  input logic               out_valid,
  input logic [NUM_GEN-1:0] pg_trig,
  input logic [NUM_GEN-1:0] pg_set,
  input logic [NUM_GEN-1:0] pg_clr,
  input logic [FN_N-1:0]    fn_strobe
);
  AST_CODE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_code != '0 |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !out_valid); // R2
  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (pg_trig == '0 && pg_set == '0 && pg_clr == '0 && fn_strobe == '0)); // R2
  AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_code == '0 |=> !out_valid); // R6
  if (USE_DEFAULTS) begin : g_def
    AST_STOP_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && evt_code == 8'h79 |=> fn_strobe[6]); // R7
    AST_BEAT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && evt_code == 8'h7A |=> fn_strobe[5]); // R7
  end
endmodule

bind evm_decoder evm_decoder_chk #(.NUM_GEN(NUM_GEN), .USE_DEFAULTS(USE_DEFAULTS)) u_chk (
  .clk (clk), .rst_n (rst_n), .evt_valid (evt_valid), .evt_code (evt_code),
  .out_valid (out_valid), .pg_trig (pg_trig), .pg_set (pg_set),
  .pg_clr (pg_clr), .fn_strobe (fn_strobe)
);

// File: tb/sim_evm_decoder.sv
`timescale 1ns/1ps
module sim_evm_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_valid = 1'b0;
  logic [7:0]   evt_code = '0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic         out_valid;
  logic [31:0]  pg_trig, pg_set, pg_clr;
  logic [10:0]  fn_strobe;

  always #4 clk = ~clk;

  evm_decoder u0 (
    .clk (clk), .rst_n (rst_n), .evt_valid (evt_valid), .evt_code (evt_code),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .out_valid (out_valid), .pg_trig (pg_trig), .pg_set (pg_set),
    .pg_clr (pg_clr), .fn_strobe (fn_strobe)
  );

  typedef struct {
    logic        v;
    logic [31:0] t, s, c;
    logic [10:0] f;
    string       req;
  } exp_t;

  exp_t         sb_q[$];
  logic [127:0] model [256];
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  function automatic logic [127:0] pat(input int c);
    logic [31:0] x;
    logic [127:0] w;
    x = 32'h9E3779B9 ^ (c * 32'h01010101) ^ (c << 13);
    for (int k = 0; k < 4; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      w[32*k +: 32] = x;
    end
    return w;
  endfunction

  function automatic logic [10:0] model_fn(input logic [7:0] code, input logic [127:0] w);
    int pos [11] = '{96, 97, 98, 99, 100, 101, 123, 124, 125, 126, 127};
    logic [10:0] f;
    for (int j = 0; j < 11; j++) f[j] = w[pos[j]];
    case (code)
      8'h70: f[0] = 1'b1;
      8'h71: f[1] = 1'b1;
      8'h7C: f[2] = 1'b1;
      8'h7D: f[3] = 1'b1;
      8'h7B: f[4] = 1'b1;
      8'h7A: f[5] = 1'b1;
      8'h79: f[6] = 1'b1;
      default: ;
    endcase
    return f;
  endfunction

  // one cycle of stimulus; expectation uses the table before any write
  task automatic cyc(input bit ev, input logic [7:0] code, input bit we,
                     input logic [7:0] wa, input logic [127:0] wd, input string req);
    exp_t e;
    @(negedge clk);
    evt_valid = ev; evt_code = code;
    wr_en = we; wr_addr = wa; wr_data = wd;
    e.req = req;
    if (ev && code != 8'h00) begin
      e.v = 1'b1;
      e.t = model[code][95:64];
      e.s = model[code][63:32];
      e.c = model[code][31:0];
      e.f = model_fn(code, model[code]);
    end else begin
      e.v = 1'b0; e.t = '0; e.s = '0; e.c = '0; e.f = '0;
    end
    sb_q.push_back(e);
    if (we) model[wa] = wd;
  endtask

  task automatic send(input logic [7:0] code, input string req);
    cyc(1'b1, code, 1'b0, 8'h00, '0, req);
  endtask

  task automatic load(input logic [7:0] a, input logic [127:0] d);
    cyc(1'b0, 8'h00, 1'b1, a, d, "R8");
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, '0, req);
  endtask

  // monitor: compares outputs after the edge that produced them
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (out_valid !== e.v || pg_trig !== e.t || pg_set !== e.s ||
            pg_clr !== e.c || fn_strobe !== e.f) begin
          n_fail++;
          $display("FAIL %s: got v=%b t=%h s=%h c=%h f=%h exp v=%b t=%h s=%h c=%h f=%h",
                   e.req, out_valid, pg_trig, pg_set, pg_clr, fn_strobe,
                   e.v, e.t, e.s, e.c, e.f);
        end
      end
    end
  end

  task automatic chk_quiet(input string req);
    n_chk++;
    if (out_valid !== 1'b0 || pg_trig !== '0 || pg_set !== '0 ||
        pg_clr !== '0 || fn_strobe !== '0) begin
      n_fail++;
      $display("FAIL %s: got v=%b t=%h s=%h c=%h f=%h exp all zero",
               req, out_valid, pg_trig, pg_set, pg_clr, fn_strobe);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    #2 chk_quiet("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2 chk_quiet("R1");
    @(posedge clk); #2 chk_quiet("R1");

    // R8: fill every entry, code 0 included with a busy word
    for (int c = 0; c < 256; c++) load(8'(c), pat(c));
    // default codes with clear words
    load(8'h70, '0); load(8'h71, '0); load(8'h79, '0); load(8'h7A, '0);
    load(8'h7B, '0); load(8'h7C, '0); load(8'h7D, '0);
    // reserved bits only
    load(8'h10, {5'b0, {21{1'b1}}, 102'b0});
    // single pulse bits
    load(8'h20, (128'h1 << 69) | (128'h1 << 63) | 128'h1);
    idle("R8");

    // R10, R3, R4: back-to-back stream
    for (int c = 1; c <= 40; c++) send(8'(c), "R10");
    send(8'h20, "R3");
    // R6: code 0 between others
    send(8'h05, "R6"); send(8'h00, "R6"); send(8'h06, "R6"); send(8'h00, "R6");
    // R2: sparse codes with gaps
    send(8'h33, "R2"); idle("R2"); send(8'h44, "R2"); idle("R2"); idle("R2");
    // R7: defaults with clear words
    send(8'h70, "R7"); send(8'h71, "R7"); send(8'h79, "R7"); send(8'h7A, "R7");
    send(8'h7B, "R7"); send(8'h7C, "R7"); send(8'h7D, "R7");
    // R7: default plus own bit, and mapped bits of other functions
    load(8'h71, (128'h1 << 97) | (128'h1 << 127) | (128'h1 << 70));
    send(8'h71, "R7");
    // R5: reserved-only word
    send(8'h10, "R5"); idle("R5");
    // R9: read and write of same code at one edge, then R8 read
    cyc(1'b1, 8'h55, 1'b1, 8'h55, ~pat(85), "R9");
    send(8'h55, "R8");
    // R4: full sweep
    for (int c = 1; c < 256; c++) send(8'(c), "R4");
    idle("R2"); idle("R2");
    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule